// File: doc/BRIEF.md
# Chunked Memory-to-SRAM Copy Engine

This block is a single-channel copy engine. It moves a block of bytes from a 64-bit host memory address into local SRAM. Software programs four values through a small register-write port: the SRAM destination, the host source address, the byte count and the transfer mode. It then writes the control word with the go bit set. The engine splits the copy into tagged read requests. The transfer mode sets the largest request size and the alignment rule. A programmable ceiling limits how many reads may be in flight at once.

Read responses come back one byte per beat, each with the tag of the request it answers. Beats for different tags may interleave, and tags may complete in any order. Each beat is written straight to SRAM at the next address recorded for its tag. When the last byte has landed, the engine drops `busy`. If the control word selected the driver as interrupt target, it also pulses `irq_done`. The snoop attribute from the control word travels unchanged on every read request.

Register selects on `reg_sel`: 0 SRAM address, 1 host address bits 31:0, 2 host address bits 63:32, 3 byte count, 4 control, 5 transfer mode.

Top module: `svc_dma`

## Requirements
- R1: A control write (select 4) with bit 31 set starts a copy, and `busy` reads 1 from the next cycle. This happens only when the engine is idle, the count is nonzero, and the SRAM address, host address (either half) and count have each been written since the previous start. Otherwise the write has no effect. A start consumes the programming, so the next start needs all three written again.
- R2: A start write while `busy` is 1 is ignored: the running copy keeps its addresses, count and snoop value.
- R3: Mode bits 9:8 give the largest request size: 0 selects 64 bytes, 1 selects 128, 2 or 3 selects 256. No request is longer than that size or crosses an address boundary that is a multiple of it.
- R4: When mode bit 10 is set and the size is 128, a request that starts on a 128-byte boundary may carry up to 128 bytes. A request that starts elsewhere ends at or before the next 64-byte boundary.
- R5: Requests cover the source range in ascending order without gaps. Each request is as long as R3 and R4 allow, except the last, which carries only the remaining bytes. Any count, including one that is not a multiple of 4, is honoured exactly.
- R6: Mode bits 3:0 set the maximum number of reads in flight. A value of 0 acts as 1, and values above 12 act as 12. Issued but not yet completed requests never exceed that number.
- R7: Each response byte for tag T is written to SRAM at the destination offset of T's request plus the number of earlier bytes of T. This holds whatever the interleaving or completion order of the tags. No two requests in flight share a tag.
- R8: `req_snoop` equals control bit 0 as written at the start, on every request of that copy.
- R9: When control bits 25:24 were 1 at the start, `irq_done` is high for exactly one cycle, the cycle after the final SRAM write. For any other value it stays low.
- R10: `busy` is 1 during every SRAM write of a copy and falls in the cycle after the final SRAM write.
- R11: After reset, `busy`, `req_valid`, `irq_done` and `sram_we` are 0.
- R12: A request held with `req_ready` low keeps its address, length and tag stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 64 | Host byte address of the request |
| req_len | output | 9 | Request length in bytes, 1 to 256 |
| req_tag | output | TAG_W | Request tag |
| req_snoop | output | 1 | Snoop attribute |
| rsp_valid | input | 1 | Response beat valid |
| rsp_tag | input | TAG_W | Tag of the response beat |
| rsp_data | input | 8 | Response byte |
| sram_we | output | 1 | SRAM byte write enable |
| sram_addr | output | SRAM_AW | SRAM byte address |
| sram_wdata | output | 8 | SRAM write byte |
| busy | output | 1 | Copy in progress |
| irq_done | output | 1 | Completion interrupt pulse |

## Verification
Suppose the per-tag table loses a tag's destination pointer or remaining length. The next response beat for that tag then lands at the wrong SRAM address, or the tag frees early. The first case is visible on `sram_addr` in the same cycle. The second shows as a stray write or a stall that holds `busy` high forever. If the in-flight counter drifts, the engine either stalls below the limit or issues one request too many. The bench catches the extra request at its acceptance, because the responder holds all data until the limit is reached. If the chunking state goes wrong, the very next request's address or length differs from the value the bench derives from the mode bits.

// File: rtl/svc_dma.sv
module svc_dma #(
  parameter int SRAM_AW = 16,
  parameter int CNT_W   = 16,
  parameter int TAG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [63:0]        req_addr,
  output logic [8:0]         req_len,
  output logic [TAG_W-1:0]   req_tag,
  output logic               req_snoop,
  input  logic               rsp_valid,
  input  logic [TAG_W-1:0]   rsp_tag,
  input  logic [7:0]         rsp_data,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [7:0]         sram_wdata,
  output logic               busy,
  output logic               irq_done
);
  localparam int NTAG    = 1 << TAG_W;
  localparam int LEN_W   = 9;
  localparam int PEND_W  = TAG_W + 1;
  localparam int LIM_MAX = (NTAG < 12) ? NTAG : 12;

  logic [SRAM_AW-1:0] sram_base_q, cur_sram;
  logic [63:0]        dram_q, cur_dram;
  logic [CNT_W-1:0]   cnt_q, cur_rem;
  logic [10:0]        mode_q, act_mode;
  logic [2:0]         prog_q;
  logic               snoop_q, busy_q, irq_q;
  logic [1:0]         tgt_q;
  logic [PEND_W-1:0]  pend_q, lim_eff;
  logic [NTAG-1:0]    tag_used;
  logic [SRAM_AW-1:0] tag_ptr  [NTAG];
  logic [LEN_W-1:0]   tag_left [NTAG];

  logic               req_v_q;
  logic [63:0]        req_addr_q;
  logic [LEN_W-1:0]   req_len_q;
  logic [TAG_W-1:0]   req_tag_q;

  logic [LEN_W-1:0]   max_sz, win, room, burst;
  logic [TAG_W-1:0]   free_tag;
  logic               have_free, start, load, rsp_hit, fin, done;

  always_comb begin
    case (act_mode[9:8])
      2'd0:    max_sz = 9'd64;
      2'd1:    max_sz = 9'd128;
      default: max_sz = 9'd256;
    endcase
  end

  assign win   = (act_mode[10] && act_mode[9:8] == 2'd1 && cur_dram[6:0] != 7'd0) ? 9'd64 : max_sz;
  assign room  = win - (cur_dram[LEN_W-1:0] & (win - 9'd1));
  assign burst = (cur_rem < CNT_W'(room)) ? cur_rem[LEN_W-1:0] : room;

  always_comb begin
    if (act_mode[3:0] == 4'd0)                  lim_eff = PEND_W'(1);
    else if (32'(act_mode[3:0]) > LIM_MAX)      lim_eff = PEND_W'(LIM_MAX);
    else                                        lim_eff = PEND_W'(act_mode[3:0]);
  end

  always_comb begin
    have_free = 1'b0;
    free_tag  = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (!tag_used[i]) begin
        have_free = 1'b1;
        free_tag  = TAG_W'(i);
      end
    end
  end

  assign start   = reg_we && reg_sel == 3'd4 && reg_wdata[31] && !busy_q &&
                   prog_q == 3'b111 && cnt_q != '0;
  assign load    = busy_q && cur_rem != '0 && pend_q < lim_eff && have_free &&
                   (!req_v_q || req_ready);
  assign rsp_hit = rsp_valid && tag_used[rsp_tag];
  assign fin     = rsp_hit && tag_left[rsp_tag] == 9'd1;
  assign done    = busy_q && fin && pend_q == PEND_W'(1) && cur_rem == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sram_base_q <= '0; dram_q <= '0; cnt_q <= '0; mode_q <= '0; prog_q <= '0;
      act_mode <= '0; snoop_q <= 1'b0; tgt_q <= '0; busy_q <= 1'b0; irq_q <= 1'b0;
      cur_dram <= '0; cur_sram <= '0; cur_rem <= '0; pend_q <= '0; tag_used <= '0;
      req_v_q <= 1'b0; req_addr_q <= '0; req_len_q <= '0; req_tag_q <= '0;
      for (int i = 0; i < NTAG; i++) begin
        tag_ptr[i]  <= '0;
        tag_left[i] <= '0;
      end
    end else begin
      irq_q <= 1'b0;
      if (reg_we) begin
        case (reg_sel)
          3'd0: begin sram_base_q <= reg_wdata[SRAM_AW-1:0]; prog_q[0] <= 1'b1; end
          3'd1: begin dram_q[31:0]  <= reg_wdata; prog_q[1] <= 1'b1; end
          3'd2: begin dram_q[63:32] <= reg_wdata; prog_q[1] <= 1'b1; end
          3'd3: begin cnt_q <= reg_wdata[CNT_W-1:0]; prog_q[2] <= 1'b1; end
          3'd5: mode_q <= reg_wdata[10:0];
          default: ;
        endcase
      end
      if (start) begin
        busy_q   <= 1'b1;
        act_mode <= mode_q;
        snoop_q  <= reg_wdata[0];
        tgt_q    <= reg_wdata[25:24];
        cur_dram <= dram_q;
        cur_sram <= sram_base_q;
        cur_rem  <= cnt_q;
        prog_q   <= '0;
      end
      if (req_v_q && req_ready) req_v_q <= 1'b0;
      if (load) begin
        req_v_q            <= 1'b1;
        req_addr_q         <= cur_dram;
        req_len_q          <= burst;
        req_tag_q          <= free_tag;
        tag_used[free_tag] <= 1'b1;
        tag_ptr[free_tag]  <= cur_sram;
        tag_left[free_tag] <= burst;
        cur_dram           <= cur_dram + 64'(burst);
        cur_sram           <= cur_sram + SRAM_AW'(burst);
        cur_rem            <= cur_rem - CNT_W'(burst);
      end
      if (rsp_hit) begin
        tag_ptr[rsp_tag]  <= tag_ptr[rsp_tag] + SRAM_AW'(1);
        tag_left[rsp_tag] <= tag_left[rsp_tag] - 9'd1;
        if (fin) tag_used[rsp_tag] <= 1'b0;
      end
      pend_q <= pend_q + PEND_W'(load) - PEND_W'(fin);
      if (done) begin
        busy_q <= 1'b0;
        irq_q  <= (tgt_q == 2'd1);
      end
    end
  end

  assign req_valid  = req_v_q;
  assign req_addr   = req_addr_q;
  assign req_len    = req_len_q;
  assign req_tag    = req_tag_q;
  assign req_snoop  = snoop_q;
  assign sram_we    = rsp_hit;
  assign sram_addr  = tag_ptr[rsp_tag];
  assign sram_wdata = rsp_data;
  assign busy       = busy_q;
  assign irq_done   = irq_q;
endmodule

// File: rtl/svc_dma_chk.sv
module svc_dma_chk #(
  parameter int TAG_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq_done,
  input logic              req_valid,
  input logic              req_ready,
  input logic [63:0]       req_addr,
  input logic [8:0]        req_len,
  input logic [TAG_W-1:0]  req_tag,
  input logic              sram_we,
  input logic [10:0]       act_mode,
  input logic [TAG_W:0]    pend_q,
  input logic [(1<<TAG_W)-1:0] tag_used
);
  logic [9:0] sz;
  logic [9:0] lim;
  always_comb begin
    sz = (act_mode[9:8] == 2'd0) ? 10'd64 : (act_mode[9:8] == 2'd1) ? 10'd128 : 10'd256;
    lim = (act_mode[3:0] == 4'd0) ? 10'd1 : (act_mode[3:0] > 4'd12) ? 10'd12 : 10'(act_mode[3:0]);
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_tag));

  p_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_len != 9'd0 && (10'(req_addr[8:0]) & (sz - 10'd1)) + 10'(req_len) <= sz);

  p_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && act_mode[10] && act_mode[9:8] == 2'd1 && req_addr[6:0] != 7'd0
      |-> 10'(req_addr[5:0]) + 10'(req_len) <= 10'd64);

  p_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    10'(pend_q) <= lim);

  p_tags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend_q) == $countones(tag_used));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !busy ##1 !irq_done);

  p_we_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> busy);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
endmodule

bind svc_dma svc_dma_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq_done(irq_done),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_len(req_len), .req_tag(req_tag), .sram_we(sram_we),
  .act_mode(act_mode), .pend_q(pend_q), .tag_used(tag_used)
);

// File: tb/svc_dma_tb_top.sv
module svc_dma_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, reg_we, req_valid, req_ready, req_snoop, rsp_valid;
  logic        sram_we, busy, irq_done;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [63:0] req_addr;
  logic [8:0]  req_len;
  logic [3:0]  req_tag, rsp_tag;
  logic [7:0]  rsp_data, sram_wdata;
  logic [15:0] sram_addr;

  svc_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_tag(req_tag), .req_snoop(req_snoop), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rsp_data(rsp_data), .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .busy(busy), .irq_done(irq_done)
  );

  typedef struct { logic [63:0] addr; int len; bit snoop; } ereq_t;
  typedef struct { int tag; logic [63:0] addr; int len; int off; } out_t;
  ereq_t       exp_q[$];
  out_t        outs[$];
  logic [7:0]  exp_mem[int];
  int n_chk = 0, n_fail = 0, cyc = 0, last_we_cyc = -10, irq_cnt = 0, lim_cur = 1;
  bit rdy_slow = 0;

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int chunk(logic [63:0] a, int rem, logic [10:0] mode);
    int mx, win, room;
    mx = (mode[9:8] == 0) ? 64 : (mode[9:8] == 1) ? 128 : 256;
    win = (mode[10] && mode[9:8] == 1 && a[6:0] != 0) ? 64 : mx;
    room = win - int'(a % 64'(win));
    return (rem < room) ? rem : room;
  endfunction

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic program_copy(int sram, logic [63:0] dram, int cnt, logic [10:0] mode, bit snoop);
    logic [63:0] a;
    int rem, s;
    wr(3'd0, 32'(sram)); wr(3'd1, dram[31:0]); wr(3'd2, dram[63:32]);
    wr(3'd3, 32'(cnt));  wr(3'd5, 32'(mode));
    a = dram; rem = cnt; s = sram;
    while (rem > 0) begin
      automatic int l = chunk(a, rem, mode);
      exp_q.push_back('{a, l, snoop});
      for (int i = 0; i < l; i++) exp_mem[(s + i) & 16'hFFFF] = mem_byte(a + 64'(i));
      a += 64'(l); s += l; rem -= l;
    end
    lim_cur = (mode[3:0] == 0) ? 1 : (mode[3:0] > 12) ? 12 : int'(mode[3:0]);
    irq_cnt = 0;
  endtask

  task automatic finish_copy(bit irq_exp, string tag);
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5", {tag, " requests left"}, exp_q.size(), 0);
    check(exp_mem.num() == 0, "R7", {tag, " bytes unwritten"}, exp_mem.num(), 0);
    check(irq_cnt == int'(irq_exp), "R9", {tag, " irq pulses"}, irq_cnt, irq_exp);
  endtask

  task automatic start(logic [31:0] ctrl, string tag);
    wr(3'd4, ctrl);
    @(negedge clk);
    check(busy == 1'b1, "R1", {tag, " busy after start"}, busy, 1);
  endtask

  task automatic no_start(logic [31:0] ctrl, string tag);
    wr(3'd4, ctrl);
    @(negedge clk);
    check(busy == 1'b0, "R1", {tag, " busy stays low"}, busy, 0);
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0, "R1", {tag, " no request"}, req_valid, 0);
  endtask

  // monitor: scoreboard pops expectations as results appear
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) check(0, "R5", "unexpected request", longint'(req_addr), 0);
        else begin
          automatic ereq_t e = exp_q.pop_front();
          check(req_addr == e.addr, "R5", "request address", longint'(req_addr), longint'(e.addr));
          check(int'(req_len) == e.len, "R3", "request length", req_len, e.len);
          check(req_snoop == e.snoop, "R8", "snoop attribute", req_snoop, e.snoop);
        end
        check(outs.size() < lim_cur, "R6", "in-flight before accept", outs.size(), lim_cur - 1);
        foreach (outs[k]) check(outs[k].tag != int'(req_tag), "R7", "tag reused", req_tag, -1);
        outs.push_back('{int'(req_tag), req_addr, int'(req_len), 0});
      end
      if (sram_we) begin
        check(busy == 1'b1, "R10", "busy during write", busy, 1);
        if (!exp_mem.exists(int'(sram_addr))) check(0, "R7", "unexpected SRAM address", sram_addr, -1);
        else begin
          check(sram_wdata == exp_mem[int'(sram_addr)], "R7", "SRAM byte",
                sram_wdata, exp_mem[int'(sram_addr)]);
          exp_mem.delete(int'(sram_addr));
        end
        last_we_cyc = cyc;
      end
      if (irq_done) begin
        irq_cnt++;
        check(cyc == last_we_cyc + 1, "R9", "irq cycle", cyc, last_we_cyc + 1);
        check(busy == 1'b0, "R10", "busy low with irq", busy, 0);
      end
    end
  end

  // responder: holds data until the limit is reached, then answers newest first
  initial begin
    rsp_valid = 1'b0; rsp_tag = '0; rsp_data = '0; req_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      rsp_valid = 1'b0;
      req_ready = rdy_slow ? (cyc % 3 != 0) : 1'b1;
      if (outs.size() > 0 && (outs.size() >= lim_cur || exp_q.size() == 0)) begin
        automatic int ix = outs.size() - 1;
        rsp_valid = 1'b1;
        rsp_tag   = 4'(outs[ix].tag);
        rsp_data  = mem_byte(outs[ix].addr + 64'(outs[ix].off));
        outs[ix].off++;
        if (outs[ix].off == outs[ix].len) outs.delete(ix);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R10", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0, "R11", "reset busy", busy, 0);
    check(req_valid == 0, "R11", "reset req_valid", req_valid, 0);
    check(irq_done == 0, "R11", "reset irq", irq_done, 0);
    check(sram_we == 0, "R11", "reset sram_we", sram_we, 0);

    no_start(32'h8100_0000, "unprogrammed");

    program_copy(16'h0100, 64'h1000, 64, 11'h004, 0);
    start(32'h8100_0000, "aligned 64");
    finish_copy(1, "aligned 64");

    rdy_slow = 1;
    program_copy(16'h0400, 64'h0000_0002_0000_2013, 301, 11'h102, 1);
    start(32'h8000_0001, "unaligned 128");
    finish_copy(0, "unaligned 128");
    rdy_slow = 0;

    program_copy(16'h1000, 64'h3050, 400, 11'h503, 0);
    start(32'h8100_0000, "split R4");
    finish_copy(1, "split R4");

    program_copy(16'h2000, 64'h40F1, 515, 11'h200, 1);
    start(32'h8100_0001, "256 limit0");
    finish_copy(1, "256 limit0");

    program_copy(16'h3000, 64'h5000, 1000, 11'h00F, 0);
    start(32'h8100_0000, "limit clamp R6");
    finish_copy(1, "limit clamp R6");

    program_copy(16'h4000, 64'h6004, 250, 11'h002, 0);
    start(32'h8200_0000, "R2 busy restart");
    repeat (5) @(posedge clk);
    wr(3'd4, 32'h8100_0001);
    finish_copy(0, "R2 busy restart");

    no_start(32'h8000_0000, "no reprogram");

    program_copy(16'h5000, 64'h707F, 1, 11'h100, 1);
    start(32'h8100_0001, "one byte");
    finish_copy(1, "one byte");

    wr(3'd0, 32'h6000); wr(3'd1, 32'h8000); wr(3'd3, 32'h0);
    no_start(32'h8000_0000, "zero count");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule